// File: doc/BRIEF.md
# Two-Bank Configuration RAM Decoder

This block decodes byte accesses to a battery-backed configuration RAM that is split into two banks by one bank-select input. Each bank covers a 7-bit offset space. The lower half of that space (offsets 0x00–0x3F) is one shared set of bytes, so the same storage is reached whichever bank is selected. In bank 0 the upper half is ordinary storage. In bank 1 the upper half is split into a fixed set of areas:

- a read-only 64-bit identifier,
- a century byte,
- a wake-up date byte,
- two control register slots, whose storage sits in a neighbouring block,
- a reserved range.

Software drives an address, a write strobe and write data, and reads back through a read-data port that follows the address combinationally. Writes take effect on the rising clock edge.

A tamper-erase input clears every writable configuration byte at a single clock edge. The identifier and the neighbouring control registers are left alone. The identifier is built from parameters: a version byte, a 48-bit unique value and a CRC-8 over those seven bytes. It is loaded at reset and never written after that.

Top module: `cmos_bank_decoder`

## Requirements
- R1: While reset is held (rst_n = 0), all writable bytes are cleared to 0x00 and the identifier is loaded from its parameters. After reset, every writable byte reads 0x00 until it is written.
- R2: With bank_sel = 1, offsets 0x00–0x3F reach the same bytes as with bank_sel = 0. A write made in either bank is read back in the other.
- R3: With bank_sel = 0, offsets 0x40–0x7F are ordinary read/write bytes. They are separate from every bank-1 location at the same offset.
- R4: In bank 1, offset 0x40 reads the ID_VERSION parameter. Offsets 0x41–0x46 read ID_UNIQUE, with offset 0x41 giving the most significant byte. Writes to 0x40–0x47 change nothing.
- R5: Bank 1 offset 0x47 reads a CRC-8 over the bytes at 0x40 to 0x46, taken in that order. The CRC uses polynomial 0x07, an initial value of 0x00, MSB first, no reflection and no final XOR.
- R6: Bank 1 offset 0x48 is the century byte. A write is stored only if the value is a legal century 00–99 in the current date mode. With date_bcd = 1, both nibbles must be 9 or less. With date_bcd = 0, the value must be at most 0x63. An illegal write leaves the old value in place.
- R7: Bank 1 offset 0x49 is a plain read/write wake-up date byte.
- R8: Bank 1 offsets 0x4A and 0x4B have no local storage.
  - A write to 0x4A raises ext_wr[0] for that cycle; a write to 0x4B raises ext_wr[1]. In both cases ext_wdata carries the written data.
  - Reads of 0x4A and 0x4B return ext_rd_a and ext_rd_b.
- R9: Bank 1 offsets 0x4C–0x7F read 0x00 and ignore writes. Such a write does not change the bank-0 byte at the same offset.
- R10: At a clock edge with erase_req = 1, the following bytes all become 0x00: the shared bytes, the bank-0 upper bytes, the century byte and the wake-up byte. The identifier is unchanged, and the erase raises no ext_wr.
- R11: When an erase and a write fall on the same edge, the erase wins for locally stored bytes: the written byte reads 0x00. A write to 0x4A or 0x4B in that cycle is still forwarded on ext_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and erase act on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 1 | Bank select: 0 = bank 0, 1 = bank 1 |
| date_bcd | input | 1 | Date mode: 1 = BCD, 0 = binary (affects century checking) |
| addr | input | 7 | Byte offset within the selected bank |
| wr_en | input | 1 | Write strobe for the current offset |
| wr_data | input | 8 | Write data |
| erase_req | input | 1 | Tamper erase request |
| rd_data | output | 8 | Read data for the current offset (combinational) |
| ext_wr | output | 2 | Write strobes to the control registers (bit 0 = 0x4A, bit 1 = 0x4B) |
| ext_wdata | output | 8 | Write data forwarded to the control registers |
| ext_rd_a | input | 8 | Read value of the control register at 0x4A |
| ext_rd_b | input | 8 | Read value of the control register at 0x4B |

## Verification
A software write and a tamper erase can arrive on the same clock edge, and the block has to pick a winner.

The bench sets up that collision on purpose. It raises erase_req in the same cycle that it writes a shared byte. It then reads that byte back and expects 0x00.

A second collision cycle pairs the erase with a write to a control-register slot. In that cycle the bench checks that ext_wr still pulses with the written data. This shows that the erase only takes priority over local storage.

// File: rtl/cmos_pkg.sv
package cmos_pkg;

   typedef enum logic [2:0] {
      RG_SHARED,
      RG_LOWUP,
      RG_ID,
      RG_CENT,
      RG_WAKE,
      RG_EXTA,
      RG_EXTB,
      RG_RSVD
   } region_e;

   // CRC-8, MSB first, init 0, over seven bytes: the top byte goes first
   function automatic logic [7:0] crc8_seven(input logic [55:0] bytes_in,
                                             input logic [7:0]  poly);
      logic [7:0] acc;
      acc = 8'h00;
      for (int b = 0; b < 7; b++) begin
         acc = acc ^ bytes_in[55 - 8*b -: 8];
         for (int k = 0; k < 8; k++) begin
            if (acc[7]) acc = {acc[6:0], 1'b0} ^ poly;
            else        acc = {acc[6:0], 1'b0};
         end
      end
      return acc;
   endfunction

endpackage

// File: rtl/cmos_region_decode.sv
module cmos_region_decode
   import cmos_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              bank_sel,
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [ADDR_W-1:0] ram_idx,
   output logic [2:0]        id_idx
);
   localparam int LO_W     = ADDR_W - 1;
   localparam int ID_SPAN  = 8;
   localparam int OFS_CENT = ID_SPAN;
   localparam int OFS_WAKE = ID_SPAN + 1;
   localparam int OFS_EXTA = ID_SPAN + 2;
   localparam int OFS_EXTB = ID_SPAN + 3;

   if (ADDR_W < 7) begin : g_bad_width
      $error("cmos_region_decode: ADDR_W must be at least 7");
   end

   logic            upper;
   logic [LO_W-1:0] lo;

   assign upper   = addr[ADDR_W-1];
   assign lo      = addr[LO_W-1:0];
   assign ram_idx = {upper, lo};
   assign id_idx  = lo[2:0];

   always_comb begin
      if (!upper)                     region = RG_SHARED;
      else if (!bank_sel)             region = RG_LOWUP;
      else if (int'(lo) < ID_SPAN)    region = RG_ID;
      else if (int'(lo) == OFS_CENT)  region = RG_CENT;
      else if (int'(lo) == OFS_WAKE)  region = RG_WAKE;
      else if (int'(lo) == OFS_EXTA)  region = RG_EXTA;
      else if (int'(lo) == OFS_EXTB)  region = RG_EXTB;
      else                            region = RG_RSVD;
   end

endmodule

// File: rtl/cmos_cfg_store.sv
module cmos_cfg_store #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase,
   input  logic              date_bcd,
   input  logic              ram_we,
   input  logic [ADDR_W-1:0] ram_idx,
   input  logic              cent_we,
   input  logic              wake_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ram_rdata,
   output logic [DATA_W-1:0] cent_q,
   output logic [DATA_W-1:0] wake_q
);
   localparam int DEPTH    = 2**ADDR_W;
   localparam int CENT_MAX = 99;

   if (DATA_W != 8) begin : g_bad_data
      $error("cmos_cfg_store: DATA_W must be 8 for century coding");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic              cent_ok;

   for (genvar g = 0; g < DEPTH; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    mem[g] <= '0;
         else if (erase)                                mem[g] <= '0;
         else if (ram_we && (int'(ram_idx) == g))       mem[g] <= wdata;
      end
   end

   assign ram_rdata = mem[ram_idx];

   always_comb begin
      if (date_bcd) cent_ok = (wdata[7:4] <= 4'd9) && (wdata[3:0] <= 4'd9);
      else          cent_ok = (int'(wdata) <= CENT_MAX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cent_q <= '0;
      else if (erase)               cent_q <= '0;
      else if (cent_we && cent_ok)  cent_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wake_q <= '0;
      else if (erase)    wake_q <= '0;
      else if (wake_we)  wake_q <= wdata;
   end

   AST_ERASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      erase |=> (cent_q == '0 && wake_q == '0 && ram_rdata == '0)); // R10

   AST_CENT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cent_q) |-> $past(erase || cent_we)); // R6

   AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wake_q) |-> $past(erase || wake_we)); // R7

endmodule

// File: rtl/cmos_id_bank.sv
module cmos_id_bank
   import cmos_pkg::*;
#(
   parameter logic [7:0]  ID_VERSION = 8'h21,
   parameter logic [47:0] ID_UNIQUE  = 48'h5A3C_9E01_7B42,
   parameter logic [7:0]  CRC_POLY   = 8'h07
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] id_idx,
   output logic [7:0] id_rdata
);
   localparam logic [55:0] BODY     = {ID_VERSION, ID_UNIQUE};
   localparam logic [7:0]  CRC_BYTE = crc8_seven(BODY, CRC_POLY);
   localparam logic [63:0] FULL     = {BODY, CRC_BYTE};

   logic [7:0] id_q [8];

   for (genvar g = 0; g < 8; g++) begin : g_id
      localparam logic [7:0] INIT = FULL[63 - 8*g -: 8];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) id_q[g] <= INIT;
         else        id_q[g] <= id_q[g];
      end
   end

   assign id_rdata = id_q[id_idx];

endmodule

// File: rtl/cmos_bank_decoder.sv
module cmos_bank_decoder
   import cmos_pkg::*;
#(
   parameter int          ADDR_W     = 7,
   parameter int          DATA_W     = 8,
   parameter logic [7:0]  ID_VERSION = 8'h21,
   parameter logic [47:0] ID_UNIQUE  = 48'h5A3C_9E01_7B42,
   parameter logic [7:0]  CRC_POLY   = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_sel,
   input  logic              date_bcd,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              erase_req,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        ext_wr,
   output logic [DATA_W-1:0] ext_wdata,
   input  logic [DATA_W-1:0] ext_rd_a,
   input  logic [DATA_W-1:0] ext_rd_b
);
   if (DATA_W != 8) begin : g_bad_data
      $error("cmos_bank_decoder: DATA_W must be 8");
   end

   region_e           region;
   logic [ADDR_W-1:0] ram_idx;
   logic [2:0]        id_idx;
   logic              ram_we, cent_we, wake_we;
   logic [DATA_W-1:0] ram_rdata, cent_q, wake_q, id_rdata;

   cmos_region_decode #(.ADDR_W(ADDR_W)) u_decode (
      .bank_sel (bank_sel),
      .addr     (addr),
      .region   (region),
      .ram_idx  (ram_idx),
      .id_idx   (id_idx)
   );

   assign ram_we    = wr_en && (region == RG_SHARED || region == RG_LOWUP);
   assign cent_we   = wr_en && (region == RG_CENT);
   assign wake_we   = wr_en && (region == RG_WAKE);
   assign ext_wr    = {wr_en && (region == RG_EXTB), wr_en && (region == RG_EXTA)};
   assign ext_wdata = wr_data;

   cmos_cfg_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .erase     (erase_req),
      .date_bcd  (date_bcd),
      .ram_we    (ram_we),
      .ram_idx   (ram_idx),
      .cent_we   (cent_we),
      .wake_we   (wake_we),
      .wdata     (wr_data),
      .ram_rdata (ram_rdata),
      .cent_q    (cent_q),
      .wake_q    (wake_q)
   );

   cmos_id_bank #(
      .ID_VERSION (ID_VERSION),
      .ID_UNIQUE  (ID_UNIQUE),
      .CRC_POLY   (CRC_POLY)
   ) u_id (
      .clk      (clk),
      .rst_n    (rst_n),
      .id_idx   (id_idx),
      .id_rdata (id_rdata)
   );

   always_comb begin
      unique case (region)
         RG_SHARED, RG_LOWUP: rd_data = ram_rdata;
         RG_ID:               rd_data = id_rdata;
         RG_CENT:             rd_data = cent_q;
         RG_WAKE:             rd_data = wake_q;
         RG_EXTA:             rd_data = ext_rd_a;
         RG_EXTB:             rd_data = ext_rd_b;
         default:             rd_data = '0;
      endcase
   end

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_RSVD) |-> (rd_data == '0)); // R9

   AST_ID_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_ID) |-> (!ram_we && !cent_we && !wake_we && ext_wr == 2'b00)); // R4

   AST_EXT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ext_wr)); // R8

   AST_LOW_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      !addr[ADDR_W-1] |-> (region == RG_SHARED && ram_idx[ADDR_W-1] == 1'b0)); // R2

   AST_ERASE_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req && !wr_en) |-> (ext_wr == 2'b00)); // R10

   AST_ID_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_ID && $past(region == RG_ID) && $stable(addr)) |-> $stable(rd_data)); // R4

endmodule

// File: tb/cmos_bank_decoder_tb.sv
module cmos_bank_decoder_tb;
   localparam int          CLK_PERIOD = 10;
   localparam logic [7:0]  VER  = 8'h21;
   localparam logic [47:0] UNIQ = 48'h5A3C_9E01_7B42;
   localparam logic [7:0]  EXT_A = 8'hA5;
   localparam logic [7:0]  EXT_B = 8'h3C;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bank_sel = 1'b0;
   logic       date_bcd = 1'b1;
   logic [6:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       erase_req = 1'b0;
   logic [7:0] rd_data;
   logic [1:0] ext_wr;
   logic [7:0] ext_wdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmos_bank_decoder u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bank_sel  (bank_sel),
      .date_bcd  (date_bcd),
      .addr      (addr),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .erase_req (erase_req),
      .rd_data   (rd_data),
      .ext_wr    (ext_wr),
      .ext_wdata (ext_wdata),
      .ext_rd_a  (EXT_A),
      .ext_rd_b  (EXT_B)
   );

   function automatic logic [7:0] model_crc();
      logic [7:0] c;
      logic [7:0] seq [7];
      seq[0] = VER;
      for (int i = 0; i < 6; i++) seq[i+1] = UNIQ[47 - 8*i -: 8];
      c = 8'h00;
      for (int i = 0; i < 7; i++) begin
         c ^= seq[i];
         for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c;
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic b, input logic [6:0] a, input logic [7:0] d);
      @(negedge clk);
      bank_sel = b; addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic b, input logic [6:0] a, output logic [7:0] d);
      @(negedge clk);
      bank_sel = b; addr = a; wr_en = 1'b0;
      #1 d = rd_data;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(0, 7'h05, v); chk("R1 shared byte after reset", v, 8'h00);
      rd(0, 7'h60, v); chk("R1 bank0 upper after reset", v, 8'h00);
      rd(1, 7'h48, v); chk("R1 century after reset", v, 8'h00);
      rd(1, 7'h40, v); chk("R1 version loaded", v, VER);
   endtask

   task automatic t_alias();
      logic [7:0] v;
      wr(0, 7'h10, 8'h5A); rd(1, 7'h10, v); chk("R2 bank0 write seen in bank1", v, 8'h5A);
      wr(1, 7'h3F, 8'hC3); rd(0, 7'h3F, v); chk("R2 bank1 write seen in bank0", v, 8'hC3);
   endtask

   task automatic t_lowup();
      logic [7:0] v;
      wr(0, 7'h48, 8'h77);
      rd(1, 7'h48, v); chk("R3 bank1 century untouched", v, 8'h00);
      rd(0, 7'h48, v); chk("R3 bank0 upper readback", v, 8'h77);
      wr(0, 7'h7F, 8'h99); rd(0, 7'h7F, v); chk("R3 bank0 top byte", v, 8'h99);
   endtask

   task automatic t_id();
      logic [7:0] v;
      for (int i = 0; i < 6; i++) begin
         rd(1, 7'(8'h41 + i), v); chk("R4 unique byte", v, UNIQ[47 - 8*i -: 8]);
      end
      wr(1, 7'h43, 8'hFF); rd(1, 7'h43, v); chk("R4 id write ignored", v, UNIQ[31:24]);
      wr(1, 7'h40, 8'h00); rd(1, 7'h40, v); chk("R4 version write ignored", v, VER);
      rd(0, 7'h43, v); chk("R4 bank0 same offset untouched", v, 8'h00);
   endtask

   task automatic t_crc();
      logic [7:0] v;
      rd(1, 7'h47, v); chk("R5 crc byte", v, model_crc());
      wr(1, 7'h47, 8'h00); rd(1, 7'h47, v); chk("R5 crc write ignored", v, model_crc());
   endtask

   task automatic t_century();
      logic [7:0] v;
      date_bcd = 1'b1;
      wr(1, 7'h48, 8'h42); rd(1, 7'h48, v); chk("R6 bcd legal", v, 8'h42);
      wr(1, 7'h48, 8'h1A); rd(1, 7'h48, v); chk("R6 bcd illegal nibble", v, 8'h42);
      wr(1, 7'h48, 8'h99); rd(1, 7'h48, v); chk("R6 bcd max", v, 8'h99);
      date_bcd = 1'b0;
      wr(1, 7'h48, 8'h63); rd(1, 7'h48, v); chk("R6 binary max", v, 8'h63);
      wr(1, 7'h48, 8'h64); rd(1, 7'h48, v); chk("R6 binary over range", v, 8'h63);
      date_bcd = 1'b1;
   endtask

   task automatic t_wake();
      logic [7:0] v;
      wr(1, 7'h49, 8'h17); rd(1, 7'h49, v); chk("R7 wake date", v, 8'h17);
   endtask

   task automatic t_ext();
      logic [7:0] v;
      @(negedge clk);
      bank_sel = 1; addr = 7'h4A; wr_data = 8'h6E; wr_en = 1'b1;
      #1 chk("R8 ext_wr for 0x4A", {6'd0, ext_wr}, 8'h01);
      chk("R8 ext_wdata", ext_wdata, 8'h6E);
      @(negedge clk);
      addr = 7'h4B; wr_data = 8'h81;
      #1 chk("R8 ext_wr for 0x4B", {6'd0, ext_wr}, 8'h02);
      @(negedge clk);
      wr_en = 1'b0;
      rd(1, 7'h4A, v); chk("R8 read 0x4A", v, EXT_A);
      rd(1, 7'h4B, v); chk("R8 read 0x4B", v, EXT_B);
      rd(1, 7'h48, v); chk("R8 century untouched", v, 8'h63);
   endtask

   task automatic t_rsvd();
      logic [7:0] v;
      wr(0, 7'h50, 8'h3D);
      wr(1, 7'h50, 8'hFF);
      rd(1, 7'h50, v); chk("R9 reserved reads zero", v, 8'h00);
      rd(0, 7'h50, v); chk("R9 bank0 same offset kept", v, 8'h3D);
      rd(1, 7'h4C, v); chk("R9 first reserved", v, 8'h00);
      rd(1, 7'h7F, v); chk("R9 last reserved", v, 8'h00);
   endtask

   task automatic t_erase();
      logic [7:0] v;
      @(negedge clk);
      erase_req = 1'b1; wr_en = 1'b0;
      #1 chk("R10 erase raises no ext_wr", {6'd0, ext_wr}, 8'h00);
      @(negedge clk);
      erase_req = 1'b0;
      rd(0, 7'h10, v); chk("R10 shared cleared", v, 8'h00);
      rd(0, 7'h3F, v); chk("R10 shared top cleared", v, 8'h00);
      rd(0, 7'h48, v); chk("R10 bank0 upper cleared", v, 8'h00);
      rd(0, 7'h50, v); chk("R10 bank0 0x50 cleared", v, 8'h00);
      rd(1, 7'h48, v); chk("R10 century cleared", v, 8'h00);
      rd(1, 7'h49, v); chk("R10 wake cleared", v, 8'h00);
      rd(1, 7'h40, v); chk("R10 version kept", v, VER);
      rd(1, 7'h47, v); chk("R10 crc kept", v, model_crc());
      rd(1, 7'h4A, v); chk("R10 ext read still live", v, EXT_A);
   endtask

   task automatic t_collide();
      logic [7:0] v;
      wr(0, 7'h22, 8'h11);
      rd(1, 7'h22, v); chk("R11 setup byte", v, 8'h11);
      @(negedge clk);
      bank_sel = 0; addr = 7'h22; wr_data = 8'hEE; wr_en = 1'b1; erase_req = 1'b1;
      @(negedge clk);
      bank_sel = 1; addr = 7'h4B; wr_data = 8'h5C;
      #1 chk("R11 ext write forwarded during erase", {6'd0, ext_wr}, 8'h02);
      chk("R11 ext data during erase", ext_wdata, 8'h5C);
      @(negedge clk);
      wr_en = 1'b0; erase_req = 1'b0;
      rd(0, 7'h22, v); chk("R11 erase beats write", v, 8'h00);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_alias();
      t_lowup();
      t_id();
      t_crc();
      t_century();
      t_wake();
      t_ext();
      t_rsvd();
      t_erase();
      t_collide();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule